// File: doc/BRIEF.md
# SMBus Configuration Register File

This block is an SMBus slave that holds a small bank of 8-bit configuration registers. Downstream logic sees them as one flat parallel bus. The slave answers one 7-bit device address. It supports three transfers: byte write, byte read (with an auto-incrementing index on further acknowledged bytes) and block read. SCL and SDA are open-drain lines. The slave receives them as plain inputs, oversamples them on the system clock, and pulls SDA low through an enable output.

The length of a block read is not fixed. It comes from a byte-count register. That register resets to a value that covers only the standard registers at indices 0 to 5, so any extra test or debug registers stay hidden until software raises the count. Bit 0 of register 0 is a global write-enable. While it is clear, every write is dropped except a write to that bit itself.

Command byte encoding: bit 7 set selects a block read, and bits 6:0 give the register index for byte transfers. Data goes out MSB first.

Top module: `smb_cfg_regs`

## Requirements
- R1: After reset every register reads 0x00, except index 6 (the byte count), which reads 6. SDA is not driven.
- R2: An address byte whose upper 7 bits equal DEV_ADDR is acknowledged (SDA pulled low in the ninth clock). Any other address is not acknowledged and the slave stays silent until the next START.
- R3: A byte write (address+W, command with bit 7 clear, one data byte) stores the data at index command[6:0] when write-enable is set. The new value appears on the parallel bus and in a later byte read.
- R4: Write-enable is bit 0 of index 0. While it is 0, writes to indices 1..15 leave them unchanged, and a write to index 0 changes only bit 0.
- R5: A byte read (address+W, command, repeated START, address+R) returns the register at index command[6:0]. Indices 16 and above read as 0x00, and writes to them change nothing.
- R6: A block read (command 0x80, repeated START, address+R) first returns the effective count. It then returns the registers from index 0 upward, one per byte.
- R7: The effective count is the value at index 6, limited to 16. Data bytes past the effective count read as 0x00, so with the default count, indices 6 and up are hidden.
- R8: Writing a larger count to index 6 makes the registers at index 7 and above appear in block reads.
- R9: A STOP or repeated START at any point, including in the middle of a data byte, returns the slave to idle or address phase. It releases SDA, and it leaves every register unchanged if the data byte was not complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_low_o | output | 1 | When high, the slave pulls SDA low |
| regs_o | output | NUM_REGS*8 | Register contents, index i at bits 8i+7:8i |

## Verification
The hardest situation to reach from the pins is a transfer cut short. One case is a STOP in the middle of a data byte. The other is a repeated START right after the command byte. In both, the slave must leave the registers alone and then serve the next transaction normally. Directed sequences drive the bus lines bit by bit to abort at those points. They then check the parallel bus and run a fresh read.

A second hard case is the link between the count register and block-read length. A directed sequence raises the count past the default, then past the array size, and reads one byte beyond the count to show the zero fill. Seeded random writes, byte reads and block reads then run against a bench model of write gating and clamping.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_RX,
    LK_RX_ACK,
    LK_TX,
    LK_TX_ACK
  } lk_state_e;

  typedef enum logic [1:0] {
    RXK_ADDR,
    RXK_CMD,
    RXK_DATA
  } rx_kind_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_hi,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_d;
  logic              sda_d;
  logic              scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_hi    = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_hi;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_hi;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int          NUM_REGS  = 16,
  parameter int          CNT_IDX   = 6,
  parameter logic [7:0]  CNT_RESET = 8'd6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  output logic [7:0]            rd_data,
  output logic [7:0]            eff_cnt,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam int         AW    = $clog2(NUM_REGS);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  logic [7:0] mem [NUM_REGS];
  logic       wen_bit;

  assign wen_bit = mem[0][0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        mem[i] <= (i == CNT_IDX) ? CNT_RESET : 8'h00;
      end
    end else if (wr_en && (wr_idx < NREG8)) begin
      if (wr_idx == 8'd0) begin
        mem[0][0] <= wr_data[0];
        if (wen_bit) mem[0][7:1] <= wr_data[7:1];
      end else if (wen_bit) begin
        mem[wr_idx[AW-1:0]] <= wr_data;
      end
    end
  end

  assign rd_data = (rd_idx < NREG8) ? mem[rd_idx[AW-1:0]] : 8'h00;
  assign eff_cnt = (mem[CNT_IDX] > NREG8) ? NREG8 : mem[CNT_IDX];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
    assign regs_o[g*8 +: 8] = mem[g];
  end

endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_hi,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  input  logic [7:0] eff_cnt,
  output logic       sda_low,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx
);

  lk_state_e  st;
  rx_kind_e   kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] cmd;
  logic [7:0] ptr;
  logic       blk;
  logic       cnt_first;
  logic       nack;
  logic [7:0] tx_byte;

  assign rd_idx  = ptr;
  assign tx_byte = (blk && cnt_first)      ? eff_cnt :
                   (blk && (ptr >= eff_cnt)) ? 8'h00   : rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= LK_IDLE;
      kind      <= RXK_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      cmd       <= '0;
      ptr       <= '0;
      blk       <= 1'b0;
      cnt_first <= 1'b0;
      nack      <= 1'b0;
      sda_low   <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        st      <= LK_IDLE;
        sda_low <= 1'b0;
      end else if (start_det) begin
        st      <= LK_RX;
        kind    <= RXK_ADDR;
        bitcnt  <= '0;
        sda_low <= 1'b0;
      end else begin
        case (st)
          LK_RX: begin
            if (scl_rise && (bitcnt < 4'd8)) begin
              shreg  <= {shreg[6:0], sda_hi};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && (bitcnt == 4'd8)) begin
              case (kind)
                RXK_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    sda_low <= 1'b1;
                    st      <= LK_RX_ACK;
                  end else begin
                    st <= LK_IDLE;
                  end
                end
                RXK_CMD: begin
                  cmd       <= shreg;
                  blk       <= shreg[7];
                  ptr       <= shreg[7] ? 8'h00 : {1'b0, shreg[6:0]};
                  cnt_first <= shreg[7];
                  sda_low   <= 1'b1;
                  st        <= LK_RX_ACK;
                end
                default: begin
                  if (!cmd[7]) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= {1'b0, cmd[6:0]};
                    wr_data <= shreg;
                  end
                  sda_low <= 1'b1;
                  st      <= LK_RX_ACK;
                end
              endcase
            end
          end
          LK_RX_ACK: begin
            if (scl_fall) begin
              sda_low <= 1'b0;
              bitcnt  <= '0;
              case (kind)
                RXK_ADDR: begin
                  if (shreg[0]) begin
                    shreg   <= tx_byte;
                    sda_low <= ~tx_byte[7];
                    st      <= LK_TX;
                    if (blk && cnt_first) cnt_first <= 1'b0;
                    else                  ptr       <= ptr + 8'd1;
                  end else begin
                    st   <= LK_RX;
                    kind <= RXK_CMD;
                  end
                end
                RXK_CMD: begin
                  st   <= LK_RX;
                  kind <= RXK_DATA;
                end
                default: st <= LK_IDLE;
              endcase
            end
          end
          LK_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_low <= 1'b0;
                st      <= LK_TX_ACK;
              end else begin
                shreg   <= {shreg[6:0], 1'b0};
                sda_low <= ~shreg[6];
              end
            end
          end
          LK_TX_ACK: begin
            if (scl_rise) begin
              nack <= sda_hi;
            end else if (scl_fall) begin
              if (nack) begin
                st <= LK_IDLE;
              end else begin
                shreg   <= tx_byte;
                sda_low <= ~tx_byte[7];
                bitcnt  <= '0;
                st      <= LK_TX;
                if (blk && cnt_first) cnt_first <= 1'b0;
                else                  ptr       <= ptr + 8'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 16,
  parameter int         CNT_IDX     = 6,
  parameter logic [7:0] CNT_RESET   = 8'd6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_low_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  logic       scl_rise;
  logic       scl_fall;
  logic       sda_hi;
  logic       start_det;
  logic       stop_det;
  logic       wr_en;
  logic [7:0] wr_idx;
  logic [7:0] wr_data;
  logic [7:0] rd_idx;
  logic [7:0] rd_data;
  logic [7:0] eff_cnt;

  smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_hi    (sda_hi),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_link_fsm #(.DEV_ADDR(DEV_ADDR)) link_i (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_hi    (sda_hi),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .eff_cnt   (eff_cnt),
    .sda_low   (sda_low_o),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx)
  );

  smb_reg_bank #(
    .NUM_REGS  (NUM_REGS),
    .CNT_IDX   (CNT_IDX),
    .CNT_RESET (CNT_RESET)
  ) bank_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .eff_cnt (eff_cnt),
    .regs_o  (regs_o)
  );

endmodule

// File: rtl/smb_cfg_regs_chk.sv
module smb_cfg_regs_chk #(
  parameter int NUM_REGS = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_low_o,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic                  wr_en,
  input logic [7:0]            wr_idx,
  input logic                  stop_det
);

  logic warm;

  always_ff @(posedge clk) begin
    if (rst) warm <= 1'b0;
    else     warm <= 1'b1;
  end

  // Slave only starts pulling SDA while SCL is low
  assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (rst || !warm)
    $rose(sda_low_o) |-> !scl_i);

  // A write strobe lasts a single cycle
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (rst || !warm)
    wr_en |=> !wr_en);

  // With write-enable clear, indices above 0 never change
  assert_we_gate_R4: assert property (@(posedge clk) disable iff (rst || !warm)
    !$past(regs_o[0]) |-> $stable(regs_o[NUM_REGS*8-1:8]));

  // Writes to indices outside the array leave the bank untouched
  assert_oob_write_R5: assert property (@(posedge clk) disable iff (rst || !warm)
    (wr_en && (wr_idx >= 8'(NUM_REGS))) |=> $stable(regs_o));

  // A STOP releases SDA
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst || !warm)
    stop_det |=> !sda_low_o);

endmodule

bind smb_cfg_regs smb_cfg_regs_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_low_o (sda_low_o),
  .regs_o    (regs_o),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .stop_det  (stop_det)
);

// File: tb/smb_cfg_regs_tb_top.sv
module smb_cfg_regs_tb_top;

  localparam int         N    = 16;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int         Q    = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           scl = 1'b1;
  logic           m_sda = 1'b1;
  logic           dut_low;
  logic           sda_line;
  logic [N*8-1:0] regs;

  int         n_tests = 0;
  int         n_fail  = 0;
  logic [7:0] model [N];
  logic [7:0] rbuf [20];

  always #2 clk = ~clk;
  assign sda_line = m_sda & ~dut_low;

  smb_cfg_regs dut_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_low_o (dut_low),
    .regs_o    (regs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic qw;
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start;
    m_sda = 1'b1; qw; scl = 1'b1; qw; m_sda = 1'b0; qw; scl = 1'b0; qw;
  endtask

  task automatic m_stop;
    m_sda = 1'b0; qw; scl = 1'b1; qw; m_sda = 1'b1; qw; qw;
  endtask

  task automatic bit_w(input logic b);
    m_sda = b; qw; scl = 1'b1; qw; qw; scl = 1'b0; qw;
  endtask

  task automatic bit_r(output logic b);
    m_sda = 1'b1; qw; scl = 1'b1; qw; b = sda_line; qw; scl = 1'b0; qw;
  endtask

  task automatic m_send(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(x);
    ack = ~x;
  endtask

  task automatic m_recv(output logic [7:0] d, input logic ack_it);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_r(x);
      d[i] = x;
    end
    bit_w(~ack_it);
  endtask

  task automatic wr_txn(input logic [7:0] idx, input logic [7:0] d);
    logic a;
    m_start; m_send({ADDR, 1'b0}, a); m_send(idx, a); m_send(d, a); m_stop;
  endtask

  task automatic rd_txn(input logic [7:0] idx, output logic [7:0] d);
    logic a;
    m_start; m_send({ADDR, 1'b0}, a); m_send(idx, a);
    m_start; m_send({ADDR, 1'b1}, a); m_recv(d, 1'b0); m_stop;
  endtask

  task automatic blk_txn(input int nb);
    logic a;
    m_start; m_send({ADDR, 1'b0}, a); m_send(8'h80, a);
    m_start; m_send({ADDR, 1'b1}, a);
    for (int k = 0; k <= nb; k++) m_recv(rbuf[k], k < nb);
    m_stop;
  endtask

  function automatic void mwrite(input int idx, input logic [7:0] d);
    if (idx >= N) return;
    if (idx == 0) begin
      if (model[0][0]) model[0] = d;
      else             model[0][0] = d[0];
    end else if (model[0][0]) begin
      model[idx] = d;
    end
  endfunction

  function automatic int eff_cnt_m();
    return (model[6] > 8'(N)) ? N : int'(model[6]);
  endfunction

  function automatic logic [7:0] exp_blk(input int k);
    int c = eff_cnt_m();
    if (k == 0) return 8'(c);
    return (k - 1 < c) ? model[k-1] : 8'h00;
  endfunction

  task automatic do_wr(input int idx, input logic [7:0] d);
    wr_txn(8'(idx), d);
    mwrite(idx, d);
  endtask

  task automatic chk_regs(input string req, input string what);
    logic [N*8-1:0] e;
    for (int i = 0; i < N; i++) e[i*8 +: 8] = model[i];
    n_tests++;
    if (regs !== e) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, regs, e);
    end
  endtask

  task automatic chk_blk(input string req, input int nb);
    blk_txn(nb);
    for (int k = 0; k <= nb; k++) chk(req, {24'h0, rbuf[k]}, {24'h0, exp_blk(k)}, $sformatf("block byte %0d", k));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] d;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < N; i++) model[i] = (i == 6) ? 8'd6 : 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1: reset contents and released SDA
    chk_regs("R1", "reset contents");
    chk("R1", {31'h0, dut_low}, 32'h0, "sda drive after reset");

    // R2: foreign address is not acknowledged, own address is
    m_start; m_send({ADDR ^ 7'h01, 1'b0}, a); m_stop;
    chk("R2", {31'h0, a}, 32'h0, "ack on foreign address");
    m_start; m_send({ADDR, 1'b0}, a); m_stop;
    chk("R2", {31'h0, a}, 32'h1, "ack on own address");

    // R4: locked writes
    do_wr(3, 8'h5A);
    chk_regs("R4", "write with enable clear");
    do_wr(0, 8'hA5);
    chk_regs("R4", "enable bit alone written");
    chk("R4", {24'h0, regs[7:0]}, 32'h01, "byte 0 after locked write");

    // R3: unlocked write and readback
    do_wr(3, 8'h5A);
    chk_regs("R3", "write with enable set");
    rd_txn(8'd3, d);
    chk("R3", {24'h0, d}, 32'h5A, "byte read after write");

    // R4: clearing enable locks again
    do_wr(0, 8'h00);
    do_wr(3, 8'h11);
    chk_regs("R4", "write after enable cleared");
    do_wr(0, 8'h01);

    // R5: out-of-range index
    do_wr(20, 8'hEE);
    chk_regs("R5", "write to index 20");
    rd_txn(8'd20, d);
    chk("R5", {24'h0, d}, 32'h0, "read of index 20");

    // R6, R7: default count hides index 6 upward
    do_wr(7, 8'h77);
    do_wr(8, 8'h88);
    chk_blk("R6", 8);
    chk("R7", {24'h0, rbuf[7]}, 32'h0, "hidden index 6 with default count");

    // R8: raise count to expose more registers
    do_wr(6, 8'd9);
    chk_blk("R8", 9);
    chk("R8", {24'h0, rbuf[9]}, 32'h88, "index 8 visible");

    // R7: count clamped to array size
    do_wr(6, 8'd40);
    chk_blk("R7", 17);
    chk("R7", {24'h0, rbuf[0]}, 32'd16, "clamped count byte");

    // R9: STOP mid data byte and repeated START after command
    m_start; m_send({ADDR, 1'b0}, a); m_send(8'd4, a);
    for (int i = 0; i < 4; i++) bit_w(1'b1);
    m_stop;
    chk_regs("R9", "stop inside data byte");
    chk("R9", {31'h0, dut_low}, 32'h0, "sda released after stop");
    m_start; m_send({ADDR, 1'b0}, a); m_send(8'd5, a);
    m_start; m_send({ADDR ^ 7'h10, 1'b0}, a); m_stop;
    chk_regs("R9", "repeated start after command");
    rd_txn(8'd3, d);
    chk("R9", {24'h0, d}, {24'h0, model[3]}, "read after aborts");

    // Random mix
    for (int it = 0; it < 30; it++) begin
      int op  = int'($urandom % 4);
      int idx = int'($urandom % 20);
      logic [7:0] rv = 8'($urandom);
      if (op < 2) begin
        do_wr(idx, rv);
        chk_regs("R3", "random write");
      end else if (op == 2) begin
        rd_txn(8'(idx), d);
        chk("R5", {24'h0, d}, {24'h0, (idx < N) ? model[idx] : 8'h00}, "random byte read");
      end else begin
        chk_blk("R6", eff_cnt_m() + 1);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule